// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage cell of a small programmable-logic macrocell. Static configuration inputs make it act as an edge-triggered D register, an edge-triggered toggle register, or a transparent D latch. The same inputs set the polarity of the data path and of the clock or enable, pick the clock source and choose the value the cell takes at power-up. The logic in front of the cell supplies a main sum term and a second term. The two terms are combined by exclusive-OR before they reach the storage element. Feeding the cell's own output back into that second term lets a D register act as a J-K or S-R flip-flop.

The clock is picked from a set of shared block clocks by a binary select. In asynchronous mode, a per-cell product-term clock may be chosen instead. Polarity inversion turns a rising active edge into a falling one, and turns an active-high latch enable into an active-low one. Three asynchronous lines act on the cell: a power-up initialization line and block-wide reset and preset lines. Configuration may only change while power-up initialization is asserted.

Top module: `macrocell_storage`

## Requirements
- R1: With `cfg_kind` = 2'b00 (D register), `q` takes the effective data input when the effective clock rises. `q` holds at both effective clock levels, on its falling edge and when the data changes.
- R2: With `cfg_kind` = 2'b01 (toggle register), `q` inverts when the effective clock rises while the effective data input is 1. `q` holds at every other time.
- R3: With `cfg_kind` = 2'b10 (latch), `q` follows the effective data input while the effective enable is 1. `q` keeps its last value while the effective enable is 0, and it follows the data again once an asynchronous force is released during transparency.
- R4: The effective clock/enable is the selected source XOR `cfg_clk_inv`. When `cfg_clk_inv` = 1, the falling edge of the source is the active edge and the low level of the source is the transparent level.
- R5: The effective data input is `d_in` XOR `xor_term` XOR `cfg_data_inv`, in every storage type.
- R6: When `cfg_async` = 0, the source is `blk_clk[cfg_clk_sel]` whatever the value of `cfg_pt_sel`. Toggling `pt_clk` or any other block clock leaves `q` unchanged.
- R7: When `cfg_async` = 1 and `cfg_pt_sel` = 1, the source is `pt_clk` and block clocks have no effect. When `cfg_async` = 1 and `cfg_pt_sel` = 0, the source is `blk_clk[cfg_clk_sel]`.
- R8: While `por` is 1, `q` equals `cfg_pwr_preset` (0 = power-up reset, 1 = power-up preset), in every storage type.
- R9: `arst` = 1 forces `q` to 0 and `apre` = 1 forces `q` to 1, without waiting for a clock. When both are 1, `q` is 0, and active clock edges during a force do not change `q`.
- R10: In D-register mode, with `xor_term` = `q` and `d_in` = J·~q + K·q, the cell behaves as a J-K flip-flop: set, reset, hold and toggle.
- R11: `cfg_kind` = 2'b11 behaves exactly as the D register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| blk_clk | input | NUM_BLK_CLK | Shared block clocks |
| pt_clk | input | 1 | Per-cell product-term clock |
| cfg_async | input | 1 | Asynchronous mode; allows the product-term clock |
| cfg_pt_sel | input | 1 | Use the product-term clock (only in asynchronous mode) |
| cfg_clk_sel | input | SEL_W | Block clock index |
| cfg_clk_inv | input | 1 | Invert clock / latch enable |
| cfg_kind | input | 2 | Storage type: 00 D reg, 01 toggle reg, 10 latch, 11 D reg |
| cfg_data_inv | input | 1 | Invert the effective data input |
| cfg_pwr_preset | input | 1 | Power-up value of q |
| por | input | 1 | Power-up initialization, active high |
| arst | input | 1 | Block asynchronous reset, active high |
| apre | input | 1 | Block asynchronous preset, active high |
| d_in | input | 1 | Main sum term |
| xor_term | input | 1 | Term XORed into the data path |
| q | output | 1 | Stored value |

## Verification
Every storage type, both polarities of clock and data, and four clock-source arrangements are swept with the same eight-step stimulus. Each step changes the data while the clock is steady, produces a rising transition and a falling transition of the selected source, and then toggles sources that should be ignored. Changing data at a steady level separates latch transparency from register hold. The two transitions separate the active edge from the inactive one, and the ignored toggles separate a correct clock multiplexer from one that picks the wrong line. Directed sequences then drive J-K feedback through all four J/K combinations, and combine reset, preset and clock edges to expose the wrong force priority or a force that waits for a clock.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
   typedef enum logic [1:0] {
      MC_DREG     = 2'b00,
      MC_TREG     = 2'b01,
      MC_LATCH    = 2'b10,
      MC_DREG_ALT = 2'b11
   } mc_kind_e;
endpackage

// File: rtl/mc_clk_select.sv
`timescale 1ns/1ps
module mc_clk_select #(
   parameter  int NUM_BLK_CLK = 4,
   localparam int SEL_W       = $clog2(NUM_BLK_CLK)
) (
   input  logic [NUM_BLK_CLK-1:0] blk_clk,
   input  logic                   pt_clk,
   input  logic                   cfg_async,
   input  logic                   cfg_pt_sel,
   input  logic [SEL_W-1:0]       cfg_clk_sel,
   input  logic                   cfg_clk_inv,
   output logic                   clk_eff
);
   logic blk_pick;
   logic use_pt;

   generate
      if ((1 << SEL_W) == NUM_BLK_CLK) begin : g_full_sel
         assign blk_pick = blk_clk[cfg_clk_sel];
      end else begin : g_clamped_sel
         // out-of-range select values fall back to clock 0
         assign blk_pick = (cfg_clk_sel < SEL_W'(NUM_BLK_CLK)) ? blk_clk[cfg_clk_sel]
                                                               : blk_clk[0];
      end
   endgenerate

   // the product-term clock is only reachable in asynchronous mode
   assign use_pt  = cfg_async & cfg_pt_sel;
   assign clk_eff = (use_pt ? pt_clk : blk_pick) ^ cfg_clk_inv;
endmodule

// File: rtl/mc_input_stage.sv
`timescale 1ns/1ps
module mc_input_stage (
   input  logic d_in,
   input  logic xor_term,
   input  logic cfg_data_inv,
   output logic din_eff
);
   // XOR stage: flip-flop emulation plus programmable polarity
   assign din_eff = d_in ^ xor_term ^ cfg_data_inv;
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
   import mc_pkg::*;
(
   input  logic     clk_eff,
   input  logic     din_eff,
   input  mc_kind_e kind,
   input  logic     force_lo,
   input  logic     force_hi,
   output logic     q
);
   logic reg_q;
   logic lat_q;
   logic reg_next;
   logic is_toggle;
   logic is_latch;
   logic force_any;

   assign is_toggle = (kind == MC_TREG);
   assign is_latch  = (kind == MC_LATCH);
   assign force_any = force_lo | force_hi;
   assign reg_next  = is_toggle ? (reg_q ^ din_eff) : din_eff;

   // edge-triggered element; the low force wins over the high force
   always_ff @(posedge clk_eff or posedge force_lo or posedge force_hi) begin
      if (force_lo)      reg_q <= 1'b0;
      else if (force_hi) reg_q <= 1'b1;
      else               reg_q <= reg_next;
   end

   // level-sensitive element, transparent while the effective enable is high
   always_latch begin
      if (force_lo)      lat_q <= 1'b0;
      else if (force_hi) lat_q <= 1'b1;
      else if (clk_eff)  lat_q <= din_eff;
   end

   assign q = is_latch ? lat_q : reg_q;

   // shadow state for the checks below: one undisturbed edge has been seen
   logic chk_armed;
   logic chk_d_prev;
   logic chk_q_prev;

   always_ff @(posedge clk_eff or posedge force_any) begin
      if (force_any) chk_armed <= 1'b0;
      else           chk_armed <= 1'b1;
   end

   always_ff @(posedge clk_eff) begin
      chk_d_prev <= din_eff;
      chk_q_prev <= reg_q;
   end

   assert_dreg_capture_R1: assert property (@(posedge clk_eff) disable iff (force_any)
      (chk_armed && (kind == MC_DREG || kind == MC_DREG_ALT)) |-> (reg_q == chk_d_prev));

   assert_treg_toggle_R2: assert property (@(posedge clk_eff) disable iff (force_any)
      (chk_armed && is_toggle) |-> (reg_q == (chk_q_prev ^ chk_d_prev)));
endmodule

// File: rtl/macrocell_storage.sv
`timescale 1ns/1ps
module macrocell_storage
   import mc_pkg::*;
#(
   parameter  int NUM_BLK_CLK = 4,
   localparam int SEL_W       = $clog2(NUM_BLK_CLK)
) (
   input  logic [NUM_BLK_CLK-1:0] blk_clk,
   input  logic                   pt_clk,
   input  logic                   cfg_async,
   input  logic                   cfg_pt_sel,
   input  logic [SEL_W-1:0]       cfg_clk_sel,
   input  logic                   cfg_clk_inv,
   input  logic [1:0]             cfg_kind,
   input  logic                   cfg_data_inv,
   input  logic                   cfg_pwr_preset,
   input  logic                   por,
   input  logic                   arst,
   input  logic                   apre,
   input  logic                   d_in,
   input  logic                   xor_term,
   output logic                   q
);
   generate
      if (NUM_BLK_CLK < 2) begin : g_bad_clk_count
         $error("macrocell_storage: NUM_BLK_CLK must be at least 2");
      end
   endgenerate

   logic clk_eff;
   logic din_eff;
   logic force_lo;
   logic force_hi;

   mc_clk_select #(.NUM_BLK_CLK(NUM_BLK_CLK)) u_clk_select (
      .blk_clk     (blk_clk),
      .pt_clk      (pt_clk),
      .cfg_async   (cfg_async),
      .cfg_pt_sel  (cfg_pt_sel),
      .cfg_clk_sel (cfg_clk_sel),
      .cfg_clk_inv (cfg_clk_inv),
      .clk_eff     (clk_eff)
   );

   mc_input_stage u_input_stage (
      .d_in         (d_in),
      .xor_term     (xor_term),
      .cfg_data_inv (cfg_data_inv),
      .din_eff      (din_eff)
   );

   // reset beats preset; power-up picks one of the two
   assign force_lo = arst | (por & ~cfg_pwr_preset);
   assign force_hi = apre | (por &  cfg_pwr_preset);

   mc_store u_store (
      .clk_eff  (clk_eff),
      .din_eff  (din_eff),
      .kind     (mc_kind_e'(cfg_kind)),
      .force_lo (force_lo),
      .force_hi (force_hi),
      .q        (q)
   );

   assert_reset_wins_R9: assert property (@(posedge clk_eff) disable iff (por)
      arst |-> (q == 1'b0));

   assert_preset_sets_R9: assert property (@(posedge clk_eff) disable iff (por)
      (apre && !arst) |-> (q == 1'b1));

   assert_powerup_value_R8: assert property (@(posedge clk_eff)
      (por && !arst && !apre) |-> (q == cfg_pwr_preset));
endmodule

// File: tb/macrocell_storage_bench.sv
`timescale 1ns/1ps
module macrocell_storage_bench;
   localparam int NCLK = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz, used for the watchdog

   logic [NCLK-1:0] blk_clk;
   logic            pt_clk, cfg_async, cfg_pt_sel, cfg_clk_inv, cfg_data_inv;
   logic            cfg_pwr_preset, por, arst, apre, d_in, xor_term;
   logic [1:0]      cfg_clk_sel, cfg_kind;
   logic            q;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   logic m;         // model value of q
   logic prev_eff;  // model effective clock level

   macrocell_storage #(.NUM_BLK_CLK(NCLK)) u_macrocell_storage (
      .blk_clk(blk_clk), .pt_clk(pt_clk), .cfg_async(cfg_async), .cfg_pt_sel(cfg_pt_sel),
      .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv), .cfg_kind(cfg_kind),
      .cfg_data_inv(cfg_data_inv), .cfg_pwr_preset(cfg_pwr_preset), .por(por),
      .arst(arst), .apre(apre), .d_in(d_in), .xor_term(xor_term), .q(q));

   function automatic logic pt_is_src();
      return cfg_async & cfg_pt_sel;
   endfunction

   function automatic logic src_level();
      return pt_is_src() ? pt_clk : blk_clk[cfg_clk_sel];
   endfunction

   task automatic chk(input string tag, input logic exp);
      checks++;
      if (q !== exp) begin
         errors++;
         $display("FAIL %s : q=%b expected %b", tag, q, exp);
      end
   endtask

   // advance the model from the current inputs, settle, compare
   task automatic step(input string tag);
      logic ne, dn;
      ne = src_level() ^ cfg_clk_inv;
      dn = d_in ^ xor_term ^ cfg_data_inv;
      if (cfg_kind == 2'b10) begin
         if (ne) m = dn;
      end else if (!prev_eff && ne) begin
         m = (cfg_kind == 2'b01) ? (m ^ dn) : dn;
      end
      prev_eff = ne;
      #1;
      chk(tag, m);
   endtask

   task automatic toggle_src();
      if (pt_is_src()) pt_clk = ~pt_clk;
      else             blk_clk[cfg_clk_sel] = ~blk_clk[cfg_clk_sel];
   endtask

   task automatic toggle_other();
      if (pt_is_src()) begin
         blk_clk[cfg_clk_sel] = ~blk_clk[cfg_clk_sel];
      end else begin
         pt_clk = ~pt_clk;
         blk_clk[cfg_clk_sel + 2'd1] = ~blk_clk[cfg_clk_sel + 2'd1];
      end
   endtask

   task automatic init_cell(input logic [1:0] kind, input logic async_m, input logic pt_sel,
                            input logic [1:0] sel, input logic cinv, input logic dinv,
                            input logic pw);
      por = 1'b1; arst = 1'b0; apre = 1'b0;
      cfg_kind = kind; cfg_async = async_m; cfg_pt_sel = pt_sel; cfg_clk_sel = sel;
      cfg_clk_inv = cinv; cfg_data_inv = dinv; cfg_pwr_preset = pw;
      blk_clk = '0; pt_clk = 1'b0; d_in = 1'b0; xor_term = 1'b0;
      m = pw;
      prev_eff = src_level() ^ cinv;
      #1;
      chk($sformatf("R8 power-up kind=%0d pw=%0d", kind, pw), pw);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog : run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // sweep: R1 R2 R3 R4 R5 R6 R7 R11
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < 4; s++)
            for (int ci = 0; ci < 2; ci++)
               for (int di = 0; di < 2; di++)
                  for (int pw = 0; pw < 2; pw++) begin
                     string tag;
                     logic [1:0] sel;
                     sel = 2'((k + s + ci + di + pw) % 4);
                     // s: 0 sync, 1 sync+pt_sel (ignored), 2 async+pt, 3 async blk
                     init_cell(2'(k), (s >= 2), (s == 1 || s == 2), sel,
                               ci[0], di[0], pw[0]);
                     tag = $sformatf("%s R4 R5 %s kind=%0d src=%0d cinv=%0d dinv=%0d",
                                     (k == 1) ? "R2" : (k == 2) ? "R3" : (k == 3) ? "R11" : "R1",
                                     (s >= 2) ? "R7" : "R6", k, s, ci, di);
                     por = 1'b0;
                     step(tag);
                     for (int n = 0; n < 8; n++) begin
                        d_in = n[0] ^ n[2]; xor_term = n[1];
                        step(tag);
                        toggle_src();   step(tag);
                        d_in = ~d_in;   step(tag);
                        toggle_src();   step(tag);
                        toggle_other(); step({tag, " ignored-source"});
                     end
                  end

      // R9: asynchronous reset and preset on a D register
      init_cell(2'b00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      por = 1'b0;
      d_in = 1'b1; #1;
      blk_clk[0] = 1'b1; #1; chk("R1 capture before force", 1'b1);
      blk_clk[0] = 1'b0; #1;
      arst = 1'b1; #1; chk("R9 reset without clock", 1'b0);
      arst = 1'b0; #1; chk("R9 stays reset after release", 1'b0);
      apre = 1'b1; #1; chk("R9 preset without clock", 1'b1);
      arst = 1'b1; #1; chk("R9 reset wins over preset", 1'b0);
      apre = 1'b0; #1; chk("R9 reset alone", 1'b0);
      blk_clk[0] = 1'b1; #1; chk("R9 edge ignored under reset", 1'b0);
      blk_clk[0] = 1'b0; #1;
      arst = 1'b0; #1;
      d_in = 1'b0; apre = 1'b1; #1;
      blk_clk[0] = 1'b1; #1; chk("R9 edge ignored under preset", 1'b1);
      blk_clk[0] = 1'b0; apre = 1'b0; #1;

      // R3/R9: force during latch transparency, then release
      init_cell(2'b10, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
      por = 1'b0;
      d_in = 1'b1; blk_clk[1] = 1'b1; #1; chk("R3 transparent", 1'b1);
      arst = 1'b1; #1; chk("R9 reset forces open latch", 1'b0);
      arst = 1'b0; #1; chk("R3 follows again after release", 1'b1);
      blk_clk[1] = 1'b0; #1;
      d_in = 1'b0; #1; chk("R3 holds when closed", 1'b1);

      // R10: J-K emulation through the XOR feedback
      init_cell(2'b00, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
      por = 1'b0; #1;
      begin
         logic [1:0] jk [8];
         logic exp;
         jk = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b11, 2'b00, 2'b10, 2'b01};
         exp = 1'b0;
         for (int i = 0; i < 8; i++) begin
            logic j, kk;
            j = jk[i][1]; kk = jk[i][0];
            xor_term = q;
            d_in = (j & ~q) | (kk & q);
            exp = j & kk ? ~exp : (j ? 1'b1 : (kk ? 1'b0 : exp));
            #1;
            blk_clk[2] = 1'b1; #1;
            chk($sformatf("R10 J=%0d K=%0d step %0d", j, kk, i), exp);
            blk_clk[2] = 1'b0; #1;
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule